// File: doc/BRIEF.md
# Strided Scratchpad Burst Address Generator

This block turns one interleaved transfer command into a sequence of burst requests between a 16 KiB on-chip scratchpad and main memory. A command carries a main-memory byte address, a scratchpad byte address, a total length in quadwords (16 bytes each) and a configuration word. The configuration word holds a skip count and a burst (transfer) count. Each burst moves up to the transfer count of quadwords. On the scratchpad side the bursts are packed back to back. On the main-memory side a gap of skip quadwords is left after each burst.

A data mover downstream takes the requests over a valid/ready handshake. When the last burst has been accepted, the block pulses `done` and is ready for the next command. The block moves no data itself. It only produces the address and length sequence.

Top module: `spad_stride_agu`

## Requirements
- R1: While reset is low, and in the first cycle after it, `req_valid`, `done` and `busy` are 0.
- R2: The configuration word's skip count is bits 7:0 and its transfer count is bits 23:16. Both are captured when a command is accepted. Changes to `cfg_word` after that have no effect on the running transfer.
- R3: Each burst length equals the transfer count, or the quadwords still remaining if that is fewer. A transfer count of 0 sends all remaining quadwords as one burst. A burst length is never 0.
- R4: After each accepted burst, the next main-memory address is the previous one plus (skip + length) × 16.
- R5: `req_saddr` is 14 bits wide. After each accepted burst it advances by length × 16, modulo 0x4000, so it wraps from the top of the scratchpad to 0.
- R6: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged.
- R7: `done` is high for exactly one cycle: the cycle after the final burst is accepted. In that cycle `req_valid` and `busy` are 0.
- R8: A command with a quadword count of 0 issues no burst. It raises `done` in the cycle after `start_valid`.
- R9: A `start_valid` pulse while `busy` is high is ignored. The running transfer continues with its own addresses and lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Command strobe; taken only when idle |
| start_maddr | input | MADDR_W (32) | Main-memory start byte address |
| start_saddr | input | SADDR_W (14) | Scratchpad start byte address |
| start_qwc | input | QWC_W (16) | Total quadwords to move |
| cfg_word | input | 32 | Skip count [7:0], transfer count [23:16] |
| busy | output | 1 | A transfer is in progress |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Consumer accepts the burst |
| req_maddr | output | MADDR_W (32) | Burst main-memory byte address |
| req_saddr | output | SADDR_W (14) | Burst scratchpad byte address |
| req_len | output | QWC_W (16) | Burst length in quadwords |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit main address, a 16 KiB scratchpad (14-bit address) and a 16-bit quadword count. With these values, the widest transfer and skip counts (255) can be reached within one 300-quadword command, which leaves a short tail burst. A command that starts at 0x3FE0 makes the scratchpad address wrap within three bursts. Every command is driven with a scrambled configuration word after acceptance, and with stalls on the ready side. Idle-only commands, zero-length commands and stray start strobes are compared against a model in the bench built from the requirements.

// File: rtl/spad_agu_pkg.sv
// Shared constants and types for the strided scratchpad burst address generator.
// Assumes byte addressing and 16-byte quadwords.
package spad_agu_pkg;

    localparam int QW_SHIFT = 4;   // log2 of quadword size in bytes
    localparam int SKIP_LSB = 0;   // skip count position in the configuration word
    localparam int SKIP_W   = 8;
    localparam int XFER_LSB = 16;  // transfer count position in the configuration word
    localparam int XFER_W   = 8;

    typedef enum logic {
        AGU_IDLE = 1'b0,
        AGU_RUN  = 1'b1
    } agu_state_e;

endpackage

// File: rtl/spad_agu_len.sv
// Burst length selector: picks the smaller of the captured transfer count and
// the remaining quadword count. A transfer count of zero means "all remaining".
// Assumes remaining is nonzero whenever the result is used.
module spad_agu_len #(
    parameter int QWC_W  = 16,
    parameter int XFER_W = 8
) (
    input  logic [QWC_W-1:0]  remaining,
    input  logic [XFER_W-1:0] xfer,
    output logic [QWC_W-1:0]  len
);

    logic [QWC_W-1:0] xfer_ext;

    // Widen the transfer count to the counter width for comparison.
    assign xfer_ext = QWC_W'(xfer);

    // Select the burst length.
    always_comb begin
        if ((xfer == '0) || (xfer_ext > remaining)) begin
            len = remaining;
        end else begin
            len = xfer_ext;
        end
    end

endmodule

// File: rtl/spad_agu_step.sv
// Address stepper: computes both addresses of the next burst from the current
// burst. The main side skips a gap, and the scratchpad side packs bursts and
// wraps at its size. Assumes the scratchpad size is a power of two, given here
// as an address width.
module spad_agu_step #(
    parameter int MADDR_W = 32,
    parameter int SADDR_W = 14,
    parameter int QWC_W   = 16,
    parameter int SKIP_W  = 8
) (
    input  logic [MADDR_W-1:0] maddr,
    input  logic [SADDR_W-1:0] saddr,
    input  logic [QWC_W-1:0]   len,
    input  logic [SKIP_W-1:0]  skip,
    output logic [MADDR_W-1:0] next_maddr,
    output logic [SADDR_W-1:0] next_saddr
);

    import spad_agu_pkg::*;

    localparam int LBYTE_W = QWC_W + QW_SHIFT;

    logic [MADDR_W-1:0] m_stride_qw;
    logic [LBYTE_W-1:0] len_bytes;

    // Main-side stride in quadwords: skip plus the burst just sent.
    assign m_stride_qw = MADDR_W'(skip) + MADDR_W'(len);

    // Scratchpad-side advance in bytes.
    assign len_bytes = {len, {QW_SHIFT{1'b0}}};

    // Form both next addresses; the scratchpad sum wraps by truncation.
    always_comb begin
        next_maddr = maddr + (m_stride_qw << QW_SHIFT);
        next_saddr = saddr + len_bytes[SADDR_W-1:0];
    end

endmodule

// File: rtl/spad_stride_agu.sv
// Strided scratchpad burst address generator (top).
// Accepts one command while idle, captures the configuration fields, and
// presents bursts over valid/ready until the count is used up, then pulses done.
// Assumes the consumer holds no expectation of bursts after done.
module spad_stride_agu #(
    parameter int MADDR_W    = 32,
    parameter int SPAD_BYTES = 16384,
    parameter int QWC_W      = 16,
    parameter int CFG_W      = 32,
    localparam int SADDR_W   = $clog2(SPAD_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    input  logic [MADDR_W-1:0] start_maddr,
    input  logic [SADDR_W-1:0] start_saddr,
    input  logic [QWC_W-1:0]   start_qwc,
    input  logic [CFG_W-1:0]   cfg_word,
    output logic               busy,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [MADDR_W-1:0] req_maddr,
    output logic [SADDR_W-1:0] req_saddr,
    output logic [QWC_W-1:0]   req_len,
    output logic               done
);

    import spad_agu_pkg::*;

    agu_state_e         state_q;
    logic [MADDR_W-1:0] maddr_q;
    logic [SADDR_W-1:0] saddr_q;
    logic [QWC_W-1:0]   rem_q;
    logic [SKIP_W-1:0]  skip_q;
    logic [XFER_W-1:0]  xfer_q;
    logic               done_q;

    logic [QWC_W-1:0]   len_w;
    logic [MADDR_W-1:0] next_maddr_w;
    logic [SADDR_W-1:0] next_saddr_w;
    logic               fire_w;
    logic               last_w;
    logic               accept_w;

    // Burst length for the current request.
    spad_agu_len #(
        .QWC_W (QWC_W),
        .XFER_W(XFER_W)
    ) u_len (
        .remaining(rem_q),
        .xfer     (xfer_q),
        .len      (len_w)
    );

    // Addresses for the request after this one.
    spad_agu_step #(
        .MADDR_W(MADDR_W),
        .SADDR_W(SADDR_W),
        .QWC_W  (QWC_W),
        .SKIP_W (SKIP_W)
    ) u_step (
        .maddr     (maddr_q),
        .saddr     (saddr_q),
        .len       (len_w),
        .skip      (skip_q),
        .next_maddr(next_maddr_w),
        .next_saddr(next_saddr_w)
    );

    // Handshake and command-acceptance terms.
    assign fire_w   = (state_q == AGU_RUN) && req_ready;
    assign last_w   = (rem_q == len_w);
    assign accept_w = (state_q == AGU_IDLE) && start_valid;

    // Sequencer: command capture, burst stepping and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= AGU_IDLE;
            maddr_q <= '0;
            saddr_q <= '0;
            rem_q   <= '0;
            skip_q  <= '0;
            xfer_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept_w) begin
                if (start_qwc == '0) begin
                    done_q <= 1'b1;
                end else begin
                    state_q <= AGU_RUN;
                    maddr_q <= start_maddr;
                    saddr_q <= start_saddr;
                    rem_q   <= start_qwc;
                    skip_q  <= cfg_word[SKIP_LSB +: SKIP_W];
                    xfer_q  <= cfg_word[XFER_LSB +: XFER_W];
                end
            end else if (fire_w) begin
                maddr_q <= next_maddr_w;
                saddr_q <= next_saddr_w;
                rem_q   <= rem_q - len_w;
                if (last_w) begin
                    state_q <= AGU_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    // Drive outputs from the registered state.
    assign busy      = (state_q == AGU_RUN);
    assign req_valid = (state_q == AGU_RUN);
    assign req_maddr = maddr_q;
    assign req_saddr = saddr_q;
    assign req_len   = len_w;
    assign done      = done_q;

endmodule

// File: rtl/spad_stride_agu_chk.sv
// Property checker for spad_stride_agu, attached by bind. It keeps its own copy
// of the configuration fields, captured from the ports when a command is taken.
module spad_stride_agu_chk #(
    parameter int MADDR_W = 32,
    parameter int SADDR_W = 14,
    parameter int QWC_W   = 16,
    parameter int CFG_W   = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_valid,
    input logic [QWC_W-1:0]   start_qwc,
    input logic [CFG_W-1:0]   cfg_word,
    input logic               busy,
    input logic               req_valid,
    input logic               req_ready,
    input logic [MADDR_W-1:0] req_maddr,
    input logic [SADDR_W-1:0] req_saddr,
    input logic [QWC_W-1:0]   req_len,
    input logic               done
);

    logic [7:0] lat_skip;
    logic [7:0] lat_xfer;

    // Capture the configuration fields seen at the port when a command is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_skip <= '0;
            lat_xfer <= '0;
        end else if (start_valid && !busy) begin
            lat_skip <= cfg_word[7:0];
            lat_xfer <= cfg_word[23:16];
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !done && !busy));

    p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_len != '0) && ((lat_xfer == '0) || (req_len <= QWC_W'(lat_xfer)))));

    p_mstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid && req_ready)) |->
        (req_maddr == $past(req_maddr) + ((MADDR_W'(lat_skip) + MADDR_W'($past(req_len))) << 4)));

    p_sstep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid && req_ready)) |->
        (req_saddr == SADDR_W'($past(req_saddr) + SADDR_W'({$past(req_len), 4'b0000}))));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable(req_maddr) && $stable(req_saddr) && $stable(req_len)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !busy && (start_qwc == '0)) |=> (done && !req_valid));

    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start_valid && !req_ready) |=>
        ($stable(req_maddr) && $stable(req_saddr) && $stable(req_len)));

endmodule

bind spad_stride_agu spad_stride_agu_chk #(
    .MADDR_W(MADDR_W),
    .SADDR_W(SADDR_W),
    .QWC_W  (QWC_W),
    .CFG_W  (CFG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_valid(start_valid),
    .start_qwc  (start_qwc),
    .cfg_word   (cfg_word),
    .busy       (busy),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_maddr  (req_maddr),
    .req_saddr  (req_saddr),
    .req_len    (req_len),
    .done       (done)
);

// File: tb/spad_stride_agu_test.sv
`timescale 1ns/1ps
module spad_stride_agu_test;

    localparam int MADDR_W = 32;
    localparam int SADDR_W = 14;
    localparam int QWC_W   = 16;
    localparam int NCASE   = 7;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start_valid = 1'b0;
    logic [MADDR_W-1:0] start_maddr = '0;
    logic [SADDR_W-1:0] start_saddr = '0;
    logic [QWC_W-1:0]   start_qwc = '0;
    logic [31:0]        cfg_word = '0;
    logic               busy;
    logic               req_valid;
    logic               req_ready = 1'b0;
    logic [MADDR_W-1:0] req_maddr;
    logic [SADDR_W-1:0] req_saddr;
    logic [QWC_W-1:0]   req_len;
    logic               done;

    int n_chk  = 0;
    int n_fail = 0;

    // Stimulus table: start fields, configuration, ready stall cycles, stray-start poke.
    localparam logic [31:0] T_MADDR [NCASE] = '{32'h0000_1000, 32'h0002_0000, 32'h0000_0040,
                                                32'h0010_0000, 32'h8000_0000, 32'hFFFF_FF00, 32'h0000_0500};
    localparam logic [13:0] T_SADDR [NCASE] = '{14'h0100, 14'h0000, 14'h0230,
                                                14'h3FE0, 14'h0010, 14'h1000, 14'h3FF0};
    localparam logic [15:0] T_QWC   [NCASE] = '{16'd10, 16'd7, 16'd5, 16'd6, 16'd300, 16'd3, 16'd1};
    localparam logic [31:0] T_CFG   [NCASE] = '{32'h0004_0002, 32'h0000_0005, 32'h0008_0000,
                                                32'h0002_0000, 32'hFFFF_FFFF, 32'h0001_0001, 32'h0003_0007};
    localparam int          T_STALL [NCASE] = '{0, 1, 0, 2, 0, 3, 1};
    localparam bit          T_POKE  [NCASE] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    spad_stride_agu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_valid(start_valid),
        .start_maddr(start_maddr),
        .start_saddr(start_saddr),
        .start_qwc  (start_qwc),
        .cfg_word   (cfg_word),
        .busy       (busy),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_maddr  (req_maddr),
        .req_saddr  (req_saddr),
        .req_len    (req_len),
        .done       (done)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One command: model the burst sequence from the requirements and compare.
    task automatic run_case(input logic [31:0] ma, input logic [13:0] sa, input logic [15:0] q,
                            input logic [31:0] cfg, input int stall, input bit poke);
        logic [15:0] rem;
        logic [31:0] em;
        logic [13:0] es;
        logic [7:0]  sk;
        logic [7:0]  xf;
        logic [15:0] len;
        bit          first;
        rem = q; em = ma; es = sa; sk = cfg[7:0]; xf = cfg[23:16]; first = 1'b1;
        @(negedge clk);
        start_maddr = ma; start_saddr = sa; start_qwc = q; cfg_word = cfg; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        cfg_word    = ~cfg;              // R2: later changes must not matter
        start_maddr = ~ma; start_saddr = ~sa; start_qwc = 16'd9;
        while (rem != 0) begin
            len = ((xf == 0) || ({8'd0, xf} > rem)) ? rem : {8'd0, xf};
            for (int s = 0; s < stall; s++) begin
                chk("R6", "held valid", {63'd0, req_valid}, 64'd1);
                chk("R6", "held maddr", {32'd0, req_maddr}, {32'd0, em});
                @(negedge clk);
            end
            if (poke && first) begin
                start_valid = 1'b1; start_qwc = 16'd0;
                @(negedge clk);
                start_valid = 1'b0;
                chk("R9", "stray start done", {63'd0, done}, 64'd0);
                chk("R9", "stray start maddr", {32'd0, req_maddr}, {32'd0, em});
            end
            chk("R3", "valid", {63'd0, req_valid}, 64'd1);
            chk("R3", "len", {48'd0, req_len}, {48'd0, len});
            chk("R4", "maddr", {32'd0, req_maddr}, {32'd0, em});
            chk("R5", "saddr", {50'd0, req_saddr}, {50'd0, es});
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            rem   = rem - len;
            em    = em + ((32'(sk) + 32'(len)) << 4);
            es    = es + 14'({len, 4'b0000});
            first = 1'b0;
            if (rem == 0) begin
                chk("R7", "done after last", {63'd0, done}, 64'd1);
                chk("R7", "valid after last", {63'd0, req_valid}, 64'd0);
                @(negedge clk);
                chk("R7", "done one cycle", {63'd0, done}, 64'd0);
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", {63'd0, req_valid}, 64'd0);
        chk("R1", "reset done", {63'd0, done}, 64'd0);
        chk("R1", "reset busy", {63'd0, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk
        for (int i = 0; i < NCASE; i++) begin
            run_case(T_MADDR[i], T_SADDR[i], T_QWC[i], T_CFG[i], T_STALL[i], T_POKE[i]);
        end

        // R8: zero-length command
        @(negedge clk);
        start_qwc = 16'd0; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        chk("R8", "zero qwc done", {63'd0, done}, 64'd1);
        chk("R8", "zero qwc no burst", {63'd0, req_valid}, 64'd0);
        @(negedge clk);
        chk("R8", "zero qwc done drops", {63'd0, done}, 64'd0);

        // R1: reset in mid-transfer clears the request
        start_maddr = 32'h100; start_saddr = 14'h0; start_qwc = 16'd8; cfg_word = 32'h0002_0000;
        start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
        chk("R1", "run before reset", {63'd0, req_valid}, 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", "valid cleared", {63'd0, req_valid}, 64'd0);
        chk("R1", "busy cleared", {63'd0, busy}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 after reset: fresh command with transfer count 0
        run_case(32'h0000_2000, 14'h0040, 16'd4, 32'h0000_0003, 0, 1'b0);

        summary();
        $finish;
    end

endmodule